// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block decides when a microcontroller goes to sleep and how it comes back. Software programs a small control register with a mode code and a sleep-enable bit. The CPU core sends a one-cycle strobe when it executes its sleep instruction. If sleep is enabled and the mode code is legal, the controller latches the mode. It then drops the clock enables for the CPU, I/O, converter and asynchronous-timer domains, and the main oscillator enable, according to that mode.

Two inputs can wake the controller: an enabled interrupt request or a reset request. On wake it first waits for the oscillator to start, but only for the modes that stopped it. It then holds the CPU halted for a fixed four cycles with all clocks running. Finally it releases the CPU with a one-cycle pulse. The pulse is on the interrupt path, or on the reset-vector path if a reset request arrived. The controller never clears register or memory contents, and it does not clear its own enable bit on wake.

Top module: `sleep_pwr_ctrl`

## Requirements
- R1: The control register is 8 bits wide and resets to 0x00. Bits 7..4 always read 0. Bits 3..0 are read/write: bits 3..1 hold the mode code and bit 0 is the sleep enable. A write shows on `reg_rdata` in the cycle after `reg_we`.
- R2: A sleep strobe taken while the enable bit is 0 has no effect, and `stat_state` stays 0 (run). A strobe with the enable at 1 and a legal code moves `stat_state` to 1 (sleep) in the next cycle.
- R3: Mode codes 100, 101 and 111 are reserved. A sleep strobe carrying one of them is ignored and the controller stays in run.
- R4: `stat_state` encodes run=0, sleep=1, start-up=2, wake-halt=3. `stat_mode` shows the mode code latched at sleep entry and does not change until the controller is back in run.
- R5: The mode codes are 000 idle, 001 converter-quiet, 010 deep-off, 011 timer-keep and 110 oscillator-hold. While asleep, the enables {cpu,io,adc,async,osc} are 01111, 00111, 00000, 00010 and 00001 respectively. In run they are all 1.
- R6: A wake from deep-off or timer-keep first spends STARTUP_CYC cycles in start-up (state 2), with the oscillator enabled. A wake from the other modes goes straight to wake-halt.
- R7: Wake-halt (state 3) lasts exactly 4 cycles, with all clock enables high. From the wake edge, `cpu_halt` therefore stays high for the start-up length plus 4 cycles.
- R8: A wake caused by `irq_req` ends with `wake_irq` high for exactly one cycle, the first cycle back in run. `wake_rst` stays low.
- R9: A `rst_req` seen while asleep, or at any point during start-up or wake-halt, makes the release pulse `wake_rst` instead of `wake_irq`.
- R10: The sleep-enable bit is not cleared by sleep or wake. It still reads 1 after the release.
- R11: `irq_req` and `rst_req` in run have no effect: no release pulse, and no state change.
- R12: `cpu_halt` is high in every state except run and low in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Control register write strobe |
| reg_wdata | input | 8 | Control register write data |
| reg_rdata | output | 8 | Control register read value |
| sleep_stb | input | 1 | One-cycle strobe: CPU executed its sleep instruction |
| irq_req | input | 1 | Enabled interrupt request (wake source) |
| rst_req | input | 1 | Reset request (wake source, reset-vector path) |
| clk_en_cpu | output | 1 | CPU clock enable |
| clk_en_io | output | 1 | I/O clock enable |
| clk_en_adc | output | 1 | Converter clock enable |
| clk_en_async | output | 1 | Asynchronous timer clock enable |
| osc_en | output | 1 | Main oscillator enable |
| cpu_halt | output | 1 | Holds the CPU stopped |
| wake_irq | output | 1 | One-cycle release to the interrupt path |
| wake_rst | output | 1 | One-cycle release to the reset-vector path |
| stat_state | output | 2 | Current controller state |
| stat_mode | output | 3 | Mode code latched at sleep entry |

## Verification
The bench sweeps all eight mode codes, with the enable both clear and set, and with both wake sources. A design that failed to decode a reserved code would fall asleep with undefined clock gating. One that ignored the enable bit would sleep on every strobe. It counts the halted cycles after each wake. A controller that applied the oscillator wait to every mode, or none, would be off by STARTUP_CYC, and an off-by-one halt counter would give 3 or 5 instead of 4. A reset request injected mid start-up checks that a late reset still switches the release to the reset path rather than being lost behind the earlier interrupt. The enable bit is read back after every wake to catch an auto-clear.

// File: rtl/slp_pkg.sv
// Shared types and mode helpers for the sleep power controller.
// Assumes a 3-bit mode code; the reserved codes are those not listed below.
package slp_pkg;

    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_SLEEP     = 2'd1,
        ST_STARTUP   = 2'd2,
        ST_WAKE_HALT = 2'd3
    } slp_state_e;

    localparam logic [MODE_W-1:0] MODE_IDLE       = 3'b000;
    localparam logic [MODE_W-1:0] MODE_CONV_QUIET = 3'b001;
    localparam logic [MODE_W-1:0] MODE_DEEP_OFF   = 3'b010;
    localparam logic [MODE_W-1:0] MODE_TIMER_KEEP = 3'b011;
    localparam logic [MODE_W-1:0] MODE_OSC_HOLD   = 3'b110;

    typedef struct packed {
        logic cpu;
        logic io;
        logic adc;
        logic async_tmr;
        logic osc;
    } clk_en_t;

    // True for the five legal mode codes.
    function automatic logic mode_valid(logic [MODE_W-1:0] m);
        return (m == MODE_IDLE) || (m == MODE_CONV_QUIET) || (m == MODE_DEEP_OFF) ||
               (m == MODE_TIMER_KEEP) || (m == MODE_OSC_HOLD);
    endfunction

    // True for modes that stop the main oscillator and need a start-up wait.
    function automatic logic needs_startup(logic [MODE_W-1:0] m);
        return (m == MODE_DEEP_OFF) || (m == MODE_TIMER_KEEP);
    endfunction

endpackage

// File: rtl/slp_ctrl_reg.sv
// Sleep control register: an enable bit plus the mode code, behind a plain
// write strobe. Assumes a single-register space (no address decode); the
// unused upper bits are not stored and read back as zero.
module slp_ctrl_reg #(
    parameter int REG_W  = 8,
    parameter int MODE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    output logic [MODE_W-1:0] mode_sel,
    output logic              sleep_en
);
    localparam int USED_W = MODE_W + 1;
    localparam int PAD_W  = REG_W - USED_W;

    logic [USED_W-1:0] bits_q;

    // Store the writable low bits; nothing clears them except reset or a write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bits_q <= '0;
        else if (wr_en)
            bits_q <= wr_data[USED_W-1:0];
    end

    assign rd_data  = {{PAD_W{1'b0}}, bits_q};
    assign mode_sel = bits_q[USED_W-1:1];
    assign sleep_en = bits_q[0];

    // R1
    reg_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_data == REG_W'($past(wr_data[USED_W-1:0]))));

    // R10
    en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && sleep_en) |=> sleep_en);

endmodule

// File: rtl/slp_seq.sv
// Sleep sequencer: decides sleep entry, latches the mode, and runs the
// start-up wait and the fixed halt window on wake. Assumes STARTUP_CYC >= 1
// and HALT_CYC >= 1, and that sleep_stb is a single-cycle pulse.
module slp_seq
    import slp_pkg::*;
#(
    parameter int STARTUP_CYC = 16,
    parameter int HALT_CYC    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_stb,
    input  logic              sleep_en,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              irq_req,
    input  logic              rst_req,
    output slp_state_e        state_o,
    output logic [MODE_W-1:0] mode_o,
    output logic              wake_irq,
    output logic              wake_rst
);
    localparam int CNT_MAX = (STARTUP_CYC > HALT_CYC) ? STARTUP_CYC : HALT_CYC;
    localparam int CNT_W   = $clog2(CNT_MAX + 1);

    slp_state_e        st_q;
    logic [MODE_W-1:0] mode_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              path_rst_q;
    logic              wake_irq_q;
    logic              wake_rst_q;

    // State machine, wait counter, wake path and release pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_RUN;
            mode_q     <= '0;
            cnt_q      <= '0;
            path_rst_q <= 1'b0;
            wake_irq_q <= 1'b0;
            wake_rst_q <= 1'b0;
        end else begin
            wake_irq_q <= 1'b0;
            wake_rst_q <= 1'b0;
            case (st_q)
                ST_RUN: begin
                    if (sleep_stb && sleep_en && mode_valid(mode_sel)) begin
                        st_q       <= ST_SLEEP;
                        mode_q     <= mode_sel;
                        path_rst_q <= 1'b0;
                    end
                end
                ST_SLEEP: begin
                    if (irq_req || rst_req) begin
                        path_rst_q <= rst_req;
                        if (needs_startup(mode_q)) begin
                            st_q  <= ST_STARTUP;
                            cnt_q <= CNT_W'(STARTUP_CYC - 1);
                        end else begin
                            st_q  <= ST_WAKE_HALT;
                            cnt_q <= CNT_W'(HALT_CYC - 1);
                        end
                    end
                end
                ST_STARTUP: begin
                    if (rst_req)
                        path_rst_q <= 1'b1;
                    if (cnt_q == '0) begin
                        st_q  <= ST_WAKE_HALT;
                        cnt_q <= CNT_W'(HALT_CYC - 1);
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: begin
                    if (rst_req)
                        path_rst_q <= 1'b1;
                    if (cnt_q == '0) begin
                        st_q       <= ST_RUN;
                        wake_irq_q <= !(path_rst_q || rst_req);
                        wake_rst_q <= path_rst_q || rst_req;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
            endcase
        end
    end

    assign state_o  = st_q;
    assign mode_o   = mode_q;
    assign wake_irq = wake_irq_q;
    assign wake_rst = wake_rst_q;

    // Checker-only count of cycles already spent in wake-halt.
    logic [CNT_W-1:0] halt_seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n || st_q != ST_WAKE_HALT)
            halt_seen_q <= '0;
        else
            halt_seen_q <= halt_seen_q + 1'b1;
    end

    // R2
    no_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && sleep_stb && !sleep_en) |=> (st_q == ST_RUN));

    // R3
    reserved_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_RUN && sleep_stb && !mode_valid(mode_sel)) |=> (st_q == ST_RUN));

    // R4
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_RUN && $past(st_q) != ST_RUN) |-> $stable(mode_q));

    // R7
    halt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WAKE_HALT) |-> (halt_seen_q < CNT_W'(HALT_CYC)));

    // R7
    halt_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_q) == ST_WAKE_HALT && st_q == ST_RUN) |->
            ($past(halt_seen_q) == CNT_W'(HALT_CYC - 1)));

    // R8
    release_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wake_irq_q && wake_rst_q));

    // R9
    release_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq_q || wake_rst_q) |-> ($past(st_q) == ST_WAKE_HALT && st_q == ST_RUN));

endmodule

// File: rtl/slp_clkgate.sv
// Clock-enable decode: maps the sequencer state and latched mode onto the
// per-domain enables and the CPU halt. Purely combinational; the clock and
// reset are used only by the checks.
module slp_clkgate
    import slp_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  slp_state_e        state_i,
    input  logic [MODE_W-1:0] mode_i,
    output clk_en_t           en_o,
    output logic              halt_o
);
    clk_en_t sleep_en_v;

    // Enable pattern for each low-power mode while fully asleep.
    always_comb begin
        case (mode_i)
            MODE_IDLE:       sleep_en_v = '{cpu:1'b0, io:1'b1, adc:1'b1, async_tmr:1'b1, osc:1'b1};
            MODE_CONV_QUIET: sleep_en_v = '{cpu:1'b0, io:1'b0, adc:1'b1, async_tmr:1'b1, osc:1'b1};
            MODE_DEEP_OFF:   sleep_en_v = '{cpu:1'b0, io:1'b0, adc:1'b0, async_tmr:1'b0, osc:1'b0};
            MODE_TIMER_KEEP: sleep_en_v = '{cpu:1'b0, io:1'b0, adc:1'b0, async_tmr:1'b1, osc:1'b0};
            MODE_OSC_HOLD:   sleep_en_v = '{cpu:1'b0, io:1'b0, adc:1'b0, async_tmr:1'b0, osc:1'b1};
            default:         sleep_en_v = '1;
        endcase
    end

    // Select the enables for the current state; start-up restarts the oscillator.
    always_comb begin
        case (state_i)
            ST_SLEEP:   en_o = sleep_en_v;
            ST_STARTUP: begin
                en_o     = sleep_en_v;
                en_o.osc = 1'b1;
            end
            default:    en_o = '1;
        endcase
    end

    assign halt_o = (state_i != ST_RUN);

    // R5
    cpu_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_SLEEP) |-> !en_o.cpu);

    // R5
    deep_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_SLEEP && mode_i == MODE_DEEP_OFF) |-> (en_o == '0));

    // R6
    osc_startup_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_STARTUP) |-> en_o.osc);

    // R7
    halt_clocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_i == ST_WAKE_HALT) |-> (halt_o && en_o == '1));

endmodule

// File: rtl/sleep_pwr_ctrl.sv
// Sleep mode power controller top: control register, sleep/wake sequencer
// and clock-enable decode. Assumes one clock domain, a synchronous
// active-low reset, and wake requests that are already masked by enables.
module sleep_pwr_ctrl
    import slp_pkg::*;
#(
    parameter int STARTUP_CYC = 16,
    parameter int HALT_CYC    = 4,
    parameter int REG_W       = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             sleep_stb,
    input  logic             irq_req,
    input  logic             rst_req,
    output logic             clk_en_cpu,
    output logic             clk_en_io,
    output logic             clk_en_adc,
    output logic             clk_en_async,
    output logic             osc_en,
    output logic             cpu_halt,
    output logic             wake_irq,
    output logic             wake_rst,
    output logic [1:0]       stat_state,
    output logic [MODE_W-1:0] stat_mode
);
    logic [MODE_W-1:0] mode_sel;
    logic              sleep_en;
    slp_state_e        seq_state;
    logic [MODE_W-1:0] seq_mode;
    clk_en_t           en;

    slp_ctrl_reg #(.REG_W(REG_W), .MODE_W(MODE_W)) u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (reg_we),
        .wr_data  (reg_wdata),
        .rd_data  (reg_rdata),
        .mode_sel (mode_sel),
        .sleep_en (sleep_en)
    );

    slp_seq #(.STARTUP_CYC(STARTUP_CYC), .HALT_CYC(HALT_CYC)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .sleep_stb (sleep_stb),
        .sleep_en  (sleep_en),
        .mode_sel  (mode_sel),
        .irq_req   (irq_req),
        .rst_req   (rst_req),
        .state_o   (seq_state),
        .mode_o    (seq_mode),
        .wake_irq  (wake_irq),
        .wake_rst  (wake_rst)
    );

    slp_clkgate u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .state_i (seq_state),
        .mode_i  (seq_mode),
        .en_o    (en),
        .halt_o  (cpu_halt)
    );

    assign clk_en_cpu   = en.cpu;
    assign clk_en_io    = en.io;
    assign clk_en_adc   = en.adc;
    assign clk_en_async = en.async_tmr;
    assign osc_en       = en.osc;
    assign stat_state   = seq_state;
    assign stat_mode    = seq_mode;

    // R12
    halt_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq || wake_rst) |-> !cpu_halt);

endmodule

// File: tb/sim_sleep_pwr_ctrl.sv
module sim_sleep_pwr_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int START_N    = 5;
    localparam int HALT_N     = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       sleep_stb = 1'b0;
    logic       irq_req = 1'b0;
    logic       rst_req = 1'b0;
    logic       clk_en_cpu, clk_en_io, clk_en_adc, clk_en_async, osc_en;
    logic       cpu_halt, wake_irq, wake_rst;
    logic [1:0] stat_state;
    logic [2:0] stat_mode;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sleep_pwr_ctrl #(.STARTUP_CYC(START_N), .HALT_CYC(HALT_N), .REG_W(8)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .sleep_stb(sleep_stb), .irq_req(irq_req),
        .rst_req(rst_req), .clk_en_cpu(clk_en_cpu), .clk_en_io(clk_en_io),
        .clk_en_adc(clk_en_adc), .clk_en_async(clk_en_async), .osc_en(osc_en),
        .cpu_halt(cpu_halt), .wake_irq(wake_irq), .wake_rst(wake_rst),
        .stat_state(stat_state), .stat_mode(stat_mode)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit legal(input int m);
        return (m == 0) || (m == 1) || (m == 2) || (m == 3) || (m == 6);
    endfunction

    // {cpu,io,adc,async,osc} while asleep, from R5
    function automatic int sleep_en_exp(input int m);
        case (m)
            0: return 5'b01111;
            1: return 5'b00111;
            2: return 5'b00000;
            3: return 5'b00010;
            default: return 5'b00001;
        endcase
    endfunction

    function automatic int en_now();
        return {clk_en_cpu, clk_en_io, clk_en_adc, clk_en_async, osc_en};
    endfunction

    task automatic write_reg(input logic [7:0] v);
        reg_wdata = v;
        reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic pulse_sleep();
        sleep_stb = 1'b1;
        @(negedge clk);
        sleep_stb = 1'b0;
    endtask

    task automatic pulse_wake(input bit use_rst);
        if (use_rst) rst_req = 1'b1; else irq_req = 1'b1;
        @(negedge clk);
        rst_req = 1'b0;
        irq_req = 1'b0;
    endtask

    // Count sampled cycles with the CPU halted; exits at the first run cycle.
    task automatic count_halt(output int n);
        n = 0;
        while (cpu_halt && n < 200) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        int n;
        int exp_len;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // Reset state
        check("R1 reset value", reg_rdata, 0);
        check("R4 reset state", stat_state, 0);
        check("R5 run enables", en_now(), 5'b11111);
        check("R12 run halt", cpu_halt, 0);

        // Upper bits never stored
        write_reg(8'hA5);
        check("R1 upper bits read zero", reg_rdata, 8'h05);
        write_reg(8'h00);

        for (int m = 0; m < 8; m++) begin
            for (int se = 0; se < 2; se++) begin
                for (int p = 0; p < 2; p++) begin
                    bit asleep;
                    write_reg({4'hC, m[2:0], se[0]});
                    check("R1 readback", reg_rdata, {4'h0, m[2:0], se[0]});
                    pulse_sleep();
                    asleep = (se == 1) && legal(m);
                    if (se == 0)
                        check("R2 sleep needs enable", stat_state, 0);
                    else if (!legal(m))
                        check("R3 reserved code ignored", stat_state, 0);
                    else
                        check("R2 sleep entered", stat_state, 1);
                    check("R12 halt level", cpu_halt, asleep);
                    if (asleep) begin
                        check("R4 latched mode", stat_mode, m);
                        check("R5 sleep enables", en_now(), sleep_en_exp(m));
                        repeat (2) @(negedge clk);
                        check("R4 remains asleep", stat_state, 1);
                        pulse_wake(p[0]);
                        if (m == 2 || m == 3) begin
                            check("R6 start-up entered", stat_state, 2);
                            check("R6 oscillator on", osc_en, 1);
                            exp_len = START_N + HALT_N;
                        end else begin
                            check("R6 no start-up", stat_state, 3);
                            check("R7 halt clocks on", en_now(), 5'b11111);
                            exp_len = HALT_N;
                        end
                        count_halt(n);
                        check("R7 halted cycle count", n, exp_len);
                        check("R4 back to run", stat_state, 0);
                        check("R8 irq release", wake_irq, (p == 0));
                        check("R9 reset release", wake_rst, (p == 1));
                        @(negedge clk);
                        check("R8 one-cycle pulse", {wake_irq, wake_rst}, 0);
                        check("R10 enable kept", reg_rdata[0], 1);
                    end else begin
                        pulse_wake(p[0]);
                        check("R11 wake in run ignored", {wake_irq, wake_rst}, 0);
                        check("R11 state in run", stat_state, 0);
                        @(negedge clk);
                        check("R11 no late pulse", {wake_irq, wake_rst}, 0);
                    end
                    write_reg(8'h00);
                end
            end
        end

        // Reset request during start-up switches the release path
        write_reg({4'h0, 3'b010, 1'b1});
        pulse_sleep();
        pulse_wake(1'b0);
        check("R6 start-up before late reset", stat_state, 2);
        pulse_wake(1'b1);
        count_halt(n);
        check("R7 length with late reset", n + 1, START_N + HALT_N);
        check("R9 late reset wins", wake_rst, 1);
        check("R9 no irq release", wake_irq, 0);

        // Reset request during wake-halt of idle
        write_reg({4'h0, 3'b000, 1'b1});
        pulse_sleep();
        pulse_wake(1'b0);
        @(negedge clk);
        check("R7 in wake-halt", stat_state, 3);
        pulse_wake(1'b1);
        count_halt(n);
        check("R9 reset in halt", wake_rst, 1);
        check("R10 enable still set", reg_rdata, 8'h01);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule